// File: doc/BRIEF.md
# Fetch-Stage Program-Counter Select Controller

This block steers the program counter of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). Each clock it looks at the instruction now in decode, at the decode-stage equality comparator and at a dependency flag raised by decode. From these it produces a registered 2-bit select for the PC multiplexer, a fetch-stall output and a one-cycle record of a taken transfer. It also drives a constant exception vector. Whenever a branch, a jump or a dependent instruction reaches decode, fetch is frozen until the three later stages have drained. While frozen, the PC is held and the fetch path issues no-ops.

Control is a three-state machine. ST_VECTOR is entered on reset and selects the exception vector. The transition ST_VECTOR to ST_RUN is taken on the first clock with reset low. ST_RUN is normal sequential fetch. The transition ST_RUN to ST_DRAIN is taken when decode holds a control transfer or asserts a dependency; on that edge the redirect select and the taken record are loaded, and a drain counter is set to three. The transition ST_DRAIN to ST_RUN is taken on the edge where the counter steps from one to zero. Reset returns the machine to ST_VECTOR from any state.

The opcode is bits [31:26] of the decode instruction. The codes recognised are: 0x04 branch-if-zero, 0x05 branch-if-not-zero, 0x02 and 0x03 direct jumps, and 0x12 and 0x13 register-indirect jumps. Every other code is ordinary.

Top module: `fetch_pc_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After a clock edge with `rst` high, `pc_sel` is 2'b11 (vector), `fetch_stall` is 0 and `branch_taken_q` is 0. This holds even if reset arrives in the middle of a drain.
- R2: On the first clock edge with `rst` low, `pc_sel` stays 2'b11 and decode is ignored. On the next edge, `pc_sel` becomes 2'b00 (sequential PC+4).
- R3: Branch-if-zero (opcode 0x04) in decode is taken when `cmp_equal` is 1. A taken branch loads `pc_sel` 2'b01 (direct target) and `branch_taken_q` 1. A not-taken branch loads 2'b00 and 0. Either way, fetch stalls.
- R4: Branch-if-not-zero (opcode 0x05) is taken when `cmp_equal` is 0, with the same select values, taken record and stall as R3.
- R5: Direct jumps (opcodes 0x02, 0x03) are always taken: `pc_sel` 2'b01 and `branch_taken_q` 1, whatever `cmp_equal` is, and fetch stalls.
- R6: Register-indirect jumps (opcodes 0x12, 0x13) are always taken: `pc_sel` 2'b10 and `branch_taken_q` 1, and fetch stalls.
- R7: A non-transfer opcode with `dec_dep_hazard` high stalls fetch, with `pc_sel` 2'b00 and `branch_taken_q` 0.
- R8: Once a stall starts, `fetch_stall` stays high for exactly 3 cycles. During those cycles `pc_sel` is 2'b00 and the decode inputs are ignored, with no reload and no redirect.
- R9: `branch_taken_q` is high for at most one cycle at a time. It reflects only the transfer decided on the previous edge.
- R10: A non-transfer opcode with `dec_dep_hazard` low keeps `pc_sel` at 2'b00 and `fetch_stall` low.
- R11: `exc_vector` is all zeros by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high CPU reset |
| dec_instr | input | 32 | Instruction currently in decode |
| cmp_equal | input | 1 | Decode-stage equality comparator result |
| dec_dep_hazard | input | 1 | Decode reports a data dependency |
| pc_sel | output | 2 | Registered PC multiplexer select |
| exc_vector | output | 32 | Exception / reset vector |
| fetch_stall | output | 1 | Hold PC and inject no-op |
| branch_taken_q | output | 1 | A transfer was taken on the previous edge |

## Verification
The assertions assume that `rst` is held for at least one edge before checking begins. They also assume that the decode inputs are stable around each rising edge, since the select and the drain load are sampled there. The stimulus changes every input only on the falling clock edge. During a drain it deliberately drives a register-indirect jump with the dependency flag set, so that the "ignored" rule is exercised. It returns decode to an ordinary opcode before each new table entry starts from ST_RUN.

// File: rtl/fetch_pc_pkg.sv
package fetch_pc_pkg;

    typedef enum logic [1:0] {
        SEL_SEQ = 2'b00,
        SEL_TGT = 2'b01,
        SEL_REG = 2'b10,
        SEL_VEC = 2'b11
    } pc_sel_e;

    typedef enum logic [2:0] {
        XFER_NONE,
        XFER_BR_ZERO,
        XFER_BR_NONZERO,
        XFER_JUMP_IMM,
        XFER_JUMP_REG
    } xfer_e;

    typedef enum logic [1:0] {
        ST_VECTOR,
        ST_RUN,
        ST_DRAIN
    } state_e;

    localparam int OP_W = 6;

    localparam logic [OP_W-1:0] OPC_BR_ZERO    = 6'h04;
    localparam logic [OP_W-1:0] OPC_BR_NONZERO = 6'h05;
    localparam logic [OP_W-1:0] OPC_JMP_IMM    = 6'h02;
    localparam logic [OP_W-1:0] OPC_JMP_IMM_LK = 6'h03;
    localparam logic [OP_W-1:0] OPC_JMP_REG    = 6'h12;
    localparam logic [OP_W-1:0] OPC_JMP_REG_LK = 6'h13;

endpackage

// File: rtl/pcf_xfer_decode.sv
module pcf_xfer_decode
    import fetch_pc_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int OP_LSB  = 26
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               cmp_eq,
    output xfer_e              kind,
    output logic               is_xfer,
    output logic               taken,
    output pc_sel_e            redirect_sel
);
    localparam int OP_MSB = OP_LSB + OP_W - 1;

    logic [OP_W-1:0] opc;
    assign opc = instr[OP_MSB:OP_LSB];

    always_comb begin
        unique case (opc)
            OPC_BR_ZERO:                   kind = XFER_BR_ZERO;
            OPC_BR_NONZERO:                kind = XFER_BR_NONZERO;
            OPC_JMP_IMM, OPC_JMP_IMM_LK:   kind = XFER_JUMP_IMM;
            OPC_JMP_REG, OPC_JMP_REG_LK:   kind = XFER_JUMP_REG;
            default:                       kind = XFER_NONE;
        endcase
    end

    always_comb begin
        is_xfer      = 1'b1;
        taken        = 1'b0;
        redirect_sel = SEL_SEQ;
        unique case (kind)
            XFER_BR_ZERO: begin
                taken        = cmp_eq;
                redirect_sel = cmp_eq ? SEL_TGT : SEL_SEQ;
            end
            XFER_BR_NONZERO: begin
                taken        = ~cmp_eq;
                redirect_sel = cmp_eq ? SEL_SEQ : SEL_TGT;
            end
            XFER_JUMP_IMM: begin
                taken        = 1'b1;
                redirect_sel = SEL_TGT;
            end
            XFER_JUMP_REG: begin
                taken        = 1'b1;
                redirect_sel = SEL_REG;
            end
            default: begin
                is_xfer = 1'b0;
            end
        endcase
    end

    // R6
    always_comb begin
        if (kind == XFER_JUMP_REG)
            reg_jump_sel_chk: assert (taken && redirect_sel == SEL_REG);
    end

endmodule

// File: rtl/pcf_drain_cnt.sv
module pcf_drain_cnt #(
    parameter int DRAIN_CYCLES = 3,
    localparam int CW = $clog2(DRAIN_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    output logic [CW-1:0] cnt,
    output logic          busy,
    output logic          last
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= CW'(DRAIN_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);
    assign last = (cnt == CW'(1));

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DRAIN_CYCLES));

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !load) |=> (cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/fetch_pc_ctrl.sv
module fetch_pc_ctrl
    import fetch_pc_pkg::*;
#(
    parameter int              INSTR_W      = 32,
    parameter int              ADDR_W       = 32,
    parameter int              OP_LSB       = 26,
    parameter int              DRAIN_CYCLES = 3,
    parameter logic [ADDR_W-1:0] RESET_VEC  = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] dec_instr,
    input  logic               cmp_equal,
    input  logic               dec_dep_hazard,
    output logic [1:0]         pc_sel,
    output logic [ADDR_W-1:0]  exc_vector,
    output logic               fetch_stall,
    output logic               branch_taken_q
);
    localparam int CW = $clog2(DRAIN_CYCLES + 1);

    state_e  state_q, state_d;
    xfer_e   kind;
    logic    is_xfer, taken;
    pc_sel_e redirect_sel;
    logic    stall_start;
    logic [CW-1:0] drain_cnt;
    logic    drain_busy, drain_last;

    pcf_xfer_decode #(
        .INSTR_W (INSTR_W),
        .OP_LSB  (OP_LSB)
    ) u_decode (
        .instr        (dec_instr),
        .cmp_eq       (cmp_equal),
        .kind         (kind),
        .is_xfer      (is_xfer),
        .taken        (taken),
        .redirect_sel (redirect_sel)
    );

    assign stall_start = (state_q == ST_RUN) && (is_xfer || dec_dep_hazard);

    pcf_drain_cnt #(
        .DRAIN_CYCLES (DRAIN_CYCLES)
    ) u_drain (
        .clk  (clk),
        .rst  (rst),
        .load (stall_start),
        .cnt  (drain_cnt),
        .busy (drain_busy),
        .last (drain_last)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_VECTOR: state_d = ST_RUN;
            ST_RUN:    if (stall_start) state_d = ST_DRAIN;
            ST_DRAIN:  if (drain_last)  state_d = ST_RUN;
            default:   state_d = ST_VECTOR;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_VECTOR;
        else     state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_sel         <= SEL_VEC;
            branch_taken_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_VECTOR: begin
                    pc_sel         <= SEL_VEC;
                    branch_taken_q <= 1'b0;
                end
                ST_RUN: begin
                    pc_sel         <= is_xfer ? redirect_sel : SEL_SEQ;
                    branch_taken_q <= is_xfer && taken;
                end
                default: begin
                    pc_sel         <= SEL_SEQ;
                    branch_taken_q <= 1'b0;
                end
            endcase
        end
    end

    assign fetch_stall = drain_busy;
    assign exc_vector  = RESET_VEC;

    // R9
    taken_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        branch_taken_q |=> !branch_taken_q);

    // R8
    drain_seq_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_stall |=> (pc_sel == SEL_SEQ));

    // R3
    redirect_stalls_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_sel == SEL_TGT || pc_sel == SEL_REG) |-> fetch_stall);

    // R8
    drain_state_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_stall |-> (state_q == ST_DRAIN));

endmodule

// File: tb/fetch_pc_ctrl_tb_top.sv
module fetch_pc_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] dec_instr;
    logic        cmp_equal;
    logic        dec_dep_hazard;
    logic [1:0]  pc_sel;
    logic [31:0] exc_vector;
    logic        fetch_stall;
    logic        branch_taken_q;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    fetch_pc_ctrl dut_i (
        .clk            (clk),
        .rst            (rst),
        .dec_instr      (dec_instr),
        .cmp_equal      (cmp_equal),
        .dec_dep_hazard (dec_dep_hazard),
        .pc_sel         (pc_sel),
        .exc_vector     (exc_vector),
        .fetch_stall    (fetch_stall),
        .branch_taken_q (branch_taken_q)
    );

    // entry: {opcode[5:0], cmp, dep, sel[1:0], taken, stall, req[3:0]}
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        {6'h04, 1'b1, 1'b0, 2'b01, 1'b1, 1'b1, 4'd3},   // R3 taken
        {6'h04, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 4'd3},   // R3 not taken
        {6'h05, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 4'd4},   // R4 taken
        {6'h05, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 4'd4},   // R4 not taken
        {6'h02, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 4'd5},   // R5
        {6'h03, 1'b1, 1'b0, 2'b01, 1'b1, 1'b1, 4'd5},   // R5
        {6'h12, 1'b0, 1'b0, 2'b10, 1'b1, 1'b1, 4'd6},   // R6
        {6'h13, 1'b1, 1'b0, 2'b10, 1'b1, 1'b1, 4'd6},   // R6
        {6'h08, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 4'd7},   // R7
        {6'h08, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 4'd10},  // R10
        {6'h23, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 4'd10},  // R10
        {6'h04, 1'b1, 1'b1, 2'b01, 1'b1, 1'b1, 4'd3}    // R3 with dependency
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] op, input logic c, input logic d);
        dec_instr      = {op, 26'h0155AA};
        cmp_equal      = c;
        dec_dep_hazard = d;
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        drive(6'h00, 1'b0, 1'b0);
        step();
        chk("R1 sel", 32'(pc_sel), 32'h3);
        chk("R1 stall", 32'(fetch_stall), 32'h0);
        chk("R1 taken", 32'(branch_taken_q), 32'h0);
        rst = 1'b0;
        drive(6'h12, 1'b0, 1'b1);
        step();
        chk("R2 first cycle vector held", 32'(pc_sel), 32'h3);
        chk("R2 decode ignored", 32'(fetch_stall), 32'h0);
        drive(6'h00, 1'b0, 1'b0);
        step();
        chk("R2 sequential", 32'(pc_sel), 32'h0);
    endtask

    initial begin
        rst = 1'b1;
        drive(6'h00, 1'b0, 1'b0);
        do_reset();
        chk("R11 vector", exc_vector, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [15:0] v;
            string tg;
            v  = VEC[i];
            tg = $sformatf("R%0d vec%0d", v[3:0], i);
            drive(v[15:10], v[9], v[8]);
            step();
            chk({tg, " sel"},   32'(pc_sel),         32'(v[7:6]));
            chk({tg, " taken"}, 32'(branch_taken_q), 32'(v[5]));
            chk({tg, " stall"}, 32'(fetch_stall),    32'(v[4]));
            if (v[4]) begin
                drive(6'h12, 1'b0, 1'b1);
                for (int k = 1; k <= 3; k++) begin
                    step();
                    chk($sformatf("R8 drain %0d stall", k), 32'(fetch_stall), 32'(k < 3));
                    chk($sformatf("R8 drain %0d sel", k), 32'(pc_sel), 32'h0);
                    chk($sformatf("R9 drain %0d taken", k), 32'(branch_taken_q), 32'h0);
                end
            end
            drive(6'h00, 1'b0, 1'b0);
            step();
            chk({tg, " R10 idle sel"}, 32'(pc_sel), 32'h0);
            chk({tg, " R10 idle stall"}, 32'(fetch_stall), 32'h0);
        end

        // R1: reset in the middle of a drain
        drive(6'h02, 1'b0, 1'b0);
        step();
        chk("R5 pre-reset sel", 32'(pc_sel), 32'h1);
        drive(6'h00, 1'b0, 1'b0);
        step();
        chk("R8 mid drain", 32'(fetch_stall), 32'h1);
        do_reset();
        chk("R11 vector after reset", exc_vector, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule